// File: doc/BRIEF.md
# SIMD Arithmetic NaN Resolution Unit

This unit settles the special-case outcome of one packed lane of a floating-point add, subtract, multiply, divide or square root, in single or double precision. It inspects the operands for signaling and quiet NaNs. It decides which NaN reaches the result and quiets a signaling NaN on the way. When an invalid operation has no NaN input, it substitutes the default NaN.

The arithmetic itself is computed elsewhere. That datapath supplies a normal result, its post-computation flags and a hint that the operation is invalid without any NaN being involved (for example infinity minus infinity, 0/0 or the square root of a negative value). The unit reports an invalid flag. When invalid is unmasked, it also raises a suppressed flag, which tells the writer to leave the destination alone.

Inputs are taken with a valid/ready handshake, and the outputs are registered one cycle later. The registered outputs stay stable while the consumer is not ready.

Top module: `simd_nan_resolve`

## Requirements
- R1: After reset out_valid is 0. An input is accepted on a clock edge where in_valid and in_ready are both 1, and in_ready equals (not out_valid) or out_ready. An accepted input appears on the outputs after that edge with out_valid 1. While out_valid is 1 and out_ready is 0, all outputs hold their values.
- R2: in_dp=0 selects single precision, in_dp=1 selects double precision. A single-precision operand sits in bits 31:0, and bits 63:32 of every single-precision input are ignored and driven as 0 on out_result. A value is a NaN when its exponent is all ones (bits 30:23 in single, 62:52 in double) and its fraction is nonzero. It is quiet when the top fraction bit (bit 22 in single, bit 51 in double) is 1, and signaling when that bit is 0.
- R3: When the first operand is a signaling NaN, whatever the second operand is, the result is the first operand with its top fraction bit set (OR 0x00400000 in single, 0x0008000000000000 in double), and invalid is 1.
- R4: When the first operand is a quiet NaN and the second is a signaling NaN, the result is the first operand unchanged and invalid is 1.
- R5: When the first operand is not a NaN and the second is a signaling NaN, the result is the second operand quieted as in R3, and invalid is 1.
- R6: When every NaN operand is quiet, the result is the first quiet NaN (the second operand if only it is a NaN). Invalid is 0, and the mask has no effect.
- R7: When in_inv_hint is 1 and no operand is a NaN, the result is the default NaN (0xFFC00000 single, 0xFFF8000000000000 double) and invalid is 1. When a NaN operand is present, the hint is ignored.
- R8: in_inv_mask=1 masks invalid. When invalid is 1 and the mask is 0, out_suppress is 1 and out_result is 0. Otherwise out_suppress is 0.
- R9: With no NaN operand and no hint, out_result is in_norm (low 32 bits in single). out_post (overflow, underflow, precision) passes in_post through, except that it is 0 whenever invalid is raised or any operand is a NaN.
- R10: With in_unary=1 (square root), the second operand is ignored and only the first operand is classified.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input lane valid |
| in_ready | output | 1 | Unit can accept an input |
| in_dp | input | 1 | 1 selects double precision |
| in_unary | input | 1 | 1 selects square root (one operand) |
| in_a | input | 64 | First operand |
| in_b | input | 64 | Second operand |
| in_inv_mask | input | 1 | 1 masks the invalid exception |
| in_inv_hint | input | 1 | Datapath reports invalid without a NaN input |
| in_norm | input | 64 | Normal datapath result |
| in_post | input | 3 | Post-computation flags: overflow, underflow, precision |
| out_valid | output | 1 | Output lane valid |
| out_ready | input | 1 | Consumer takes the output |
| out_result | output | 64 | Resolved lane result |
| out_invalid | output | 1 | Invalid operation raised |
| out_suppress | output | 1 | Unmasked invalid: no result is to be written |
| out_post | output | 3 | Post-computation flags after priority |

## Verification
The bench targets the asymmetric precedence cases. A design that preferred the signaling NaN would return the second operand when a quiet first operand meets a signaling second one. A design that derived invalid from the chosen NaN would miss the flag in that case. Single-precision cases carry garbage in the upper half and double-precision words whose low half looks like a single NaN, so that a wrong field position shows up as a wrongly classified operand. Other cases set the hint together with a quiet NaN, feed a signaling second operand to a square root, and give post flags to NaN and invalid lanes. A design that got these wrong would emit a default NaN, a false invalid or leaked overflow or precision flags. Random back-pressure exposes outputs that change while stalled.

// File: rtl/simd_nan_resolve.sv
module simd_nan_resolve (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        in_valid,
  output logic        in_ready,
  input  logic        in_dp,
  input  logic        in_unary,
  input  logic [63:0] in_a,
  input  logic [63:0] in_b,
  input  logic        in_inv_mask,
  input  logic        in_inv_hint,
  input  logic [63:0] in_norm,
  input  logic [2:0]  in_post,
  output logic        out_valid,
  input  logic        out_ready,
  output logic [63:0] out_result,
  output logic        out_invalid,
  output logic        out_suppress,
  output logic [2:0]  out_post
);

  localparam logic [63:0] SP_QBIT = 64'h0000_0000_0040_0000;
  localparam logic [63:0] DP_QBIT = 64'h0008_0000_0000_0000;
  localparam logic [63:0] SP_DFLT = 64'h0000_0000_FFC0_0000;
  localparam logic [63:0] DP_DFLT = 64'hFFF8_0000_0000_0000;

  function automatic logic [63:0] fit(input logic [63:0] v, input logic dp);
    return dp ? v : {32'h0, v[31:0]};
  endfunction

  function automatic logic nan_of(input logic [63:0] v, input logic dp);
    if (dp) return (&v[62:52]) && (|v[51:0]);
    else    return (&v[30:23]) && (|v[22:0]);
  endfunction

  function automatic logic quiet_of(input logic [63:0] v, input logic dp);
    return dp ? v[51] : v[22];
  endfunction

  logic [63:0] a_w, b_w, qbit, dflt;
  logic        a_nan, b_nan, a_snan, b_snan, any_nan;
  logic        inv_w, sup_w;
  logic [63:0] pick_w, res_w;
  logic        take;

  assign a_w    = fit(in_a, in_dp);
  assign b_w    = fit(in_b, in_dp);
  assign qbit   = in_dp ? DP_QBIT : SP_QBIT;
  assign dflt   = in_dp ? DP_DFLT : SP_DFLT;

  assign a_nan  = nan_of(a_w, in_dp);
  assign b_nan  = !in_unary && nan_of(b_w, in_dp);
  assign a_snan = a_nan && !quiet_of(a_w, in_dp);
  assign b_snan = b_nan && !quiet_of(b_w, in_dp);
  assign any_nan = a_nan || b_nan;

  assign inv_w  = a_snan || b_snan || (!any_nan && in_inv_hint);
  assign sup_w  = inv_w && !in_inv_mask;

  always_comb begin
    if (a_nan)            pick_w = a_w | qbit;
    else if (b_nan)       pick_w = b_w | qbit;
    else if (in_inv_hint) pick_w = dflt;
    else                  pick_w = fit(in_norm, in_dp);
  end

  assign res_w    = sup_w ? 64'h0 : pick_w;
  assign in_ready = !out_valid || out_ready;
  assign take     = in_valid && in_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid    <= 1'b0;
      out_result   <= 64'h0;
      out_invalid  <= 1'b0;
      out_suppress <= 1'b0;
      out_post     <= 3'b000;
    end else if (take) begin
      out_valid    <= 1'b1;
      out_result   <= res_w;
      out_invalid  <= inv_w;
      out_suppress <= sup_w;
      out_post     <= (inv_w || any_nan) ? 3'b000 : in_post;
    end else if (out_ready) begin
      out_valid    <= 1'b0;
    end
  end

endmodule

module simd_nan_resolve_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        in_valid,
  input logic        in_ready,
  input logic        in_inv_mask,
  input logic        out_valid,
  input logic        out_ready,
  input logic [63:0] out_result,
  input logic        out_invalid,
  input logic        out_suppress,
  input logic [2:0]  out_post
);

  // R1
  accept_to_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready |=> out_valid);

  // R1
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_result) &&
    $stable(out_invalid) && $stable(out_suppress) && $stable(out_post));

  // R8
  suppress_implies_invalid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_suppress |-> out_invalid && out_result == 64'h0);

  // R8
  masked_no_suppress_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready && in_inv_mask |=> !out_suppress);

  // R9
  invalid_clears_post_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_invalid |-> out_post == 3'b000);

endmodule

bind simd_nan_resolve simd_nan_resolve_chk chk_i (.*);

// File: tb/simd_nan_resolve_tb_top.sv
module simd_nan_resolve_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0, in_ready;
  logic        in_dp = 1'b0, in_unary = 1'b0, in_inv_mask = 1'b1, in_inv_hint = 1'b0;
  logic [63:0] in_a = '0, in_b = '0, in_norm = '0;
  logic [2:0]  in_post = '0;
  logic        out_valid, out_ready = 1'b1;
  logic [63:0] out_result;
  logic        out_invalid, out_suppress;
  logic [2:0]  out_post;

  always #2 clk = ~clk;

  simd_nan_resolve dut_i (.*);

  typedef struct packed {
    logic [63:0] res;
    logic        inv;
    logic        sup;
    logic [2:0]  post;
  } exp_t;

  exp_t  exp_q[$];
  string tag_q[$];
  int    checks = 0, errors = 0, cyc = 0;
  logic  drain = 1'b0;

  task automatic chk(string tag, string what, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic send(string tag, logic dp, logic un, logic [63:0] a, logic [63:0] b,
                      logic msk, logic hint, logic [63:0] norm, logic [2:0] post, exp_t e);
    @(negedge clk); #1;
    in_valid = 1; in_dp = dp; in_unary = un; in_a = a; in_b = b;
    in_inv_mask = msk; in_inv_hint = hint; in_norm = norm; in_post = post;
    while (!in_ready) begin @(negedge clk); #1; end
    exp_q.push_back(e); tag_q.push_back(tag);
    @(posedge clk); #1;
    in_valid = 0;
  endtask

  function automatic exp_t mk(logic [63:0] r, logic i, logic s, logic [2:0] p);
    exp_t e; e.res = r; e.inv = i; e.sup = s; e.post = p; return e;
  endfunction

  logic        stalled = 0;
  logic [63:0] held;
  initial begin
    forever begin
      @(negedge clk);
      cyc++;
      if (stalled) begin
        chk("R1", "stall valid", {63'h0, out_valid}, 64'h1);
        chk("R1", "stall hold", out_result, held);
      end
      out_ready = drain || (cyc % 4 != 3);
      stalled = out_valid && !out_ready;
      held = out_result;
      if (out_valid && out_ready) begin
        if (exp_q.size() == 0) begin
          chk("R1", "unexpected output", 64'h1, 64'h0);
        end else begin
          exp_t e; string t;
          e = exp_q.pop_front(); t = tag_q.pop_front();
          chk(t, "result", out_result, e.res);
          chk(t, "invalid", {63'h0, out_invalid}, {63'h0, e.inv});
          chk(t, "suppress", {63'h0, out_suppress}, {63'h0, e.sup});
          chk(t, "post", {61'h0, out_post}, {61'h0, e.post});
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  localparam logic [63:0] S_SN  = 64'h7F80_0001, S_SN2 = 64'h7F80_0002;
  localparam logic [63:0] S_QN  = 64'h7FC0_0005, S_QN2 = 64'h7FC0_0009;
  localparam logic [63:0] S_ONE = 64'h3F80_0000, S_NSN = 64'hFF80_0123;
  localparam logic [63:0] D_SN  = 64'h7FF0_0000_0000_0001, D_QN = 64'h7FF8_0000_0000_0007;
  localparam logic [63:0] D_ONE = 64'h3FF0_0000_0000_0000;

  initial begin
    repeat (3) @(posedge clk);
    #1;
    chk("R1", "reset out_valid", {63'h0, out_valid}, 64'h0);
    chk("R1", "reset in_ready", {63'h0, in_ready}, 64'h1);
    rst_n = 1;
    // R3 single
    send("R3", 0, 0, S_SN, S_SN2, 1, 0, 0, 3'b111, mk(64'h7FC0_0001, 1, 0, 0));
    send("R3", 0, 0, S_SN, S_QN, 1, 0, 0, 3'b000, mk(64'h7FC0_0001, 1, 0, 0));
    send("R3", 1, 0, D_SN, D_ONE, 1, 0, 0, 3'b000, mk(64'h7FF8_0000_0000_0001, 1, 0, 0));
    // R4
    send("R4", 0, 0, S_QN, S_SN, 1, 0, 0, 3'b000, mk(S_QN, 1, 0, 0));
    send("R4", 1, 0, D_QN, D_SN, 1, 0, 0, 3'b000, mk(D_QN, 1, 0, 0));
    // R5
    send("R5", 0, 0, S_ONE, S_NSN, 1, 0, 0, 3'b000, mk(64'hFFC0_0123, 1, 0, 0));
    // R6
    send("R6", 0, 0, S_ONE, S_QN, 0, 0, 0, 3'b010, mk(S_QN, 0, 0, 0));
    send("R6", 0, 0, S_QN, S_QN2, 0, 0, 0, 3'b000, mk(S_QN, 0, 0, 0));
    send("R6", 0, 0, S_QN, S_QN2, 1, 0, 0, 3'b000, mk(S_QN, 0, 0, 0));
    // R7
    send("R7", 0, 0, S_ONE, S_ONE, 1, 1, 64'h1234, 3'b101, mk(64'hFFC0_0000, 1, 0, 0));
    send("R7", 1, 0, D_ONE, D_ONE, 1, 1, 64'h1234, 3'b000, mk(64'hFFF8_0000_0000_0000, 1, 0, 0));
    send("R7", 0, 0, S_QN, S_ONE, 1, 1, 64'h1234, 3'b000, mk(S_QN, 0, 0, 0));
    // R8
    send("R8", 0, 0, S_SN, S_ONE, 0, 0, 0, 3'b000, mk(64'h0, 1, 1, 0));
    send("R8", 1, 0, D_ONE, D_ONE, 0, 1, 0, 3'b000, mk(64'h0, 1, 1, 0));
    send("R8", 0, 0, S_ONE, S_ONE, 0, 0, 64'h4049_0FDB, 3'b000, mk(64'h4049_0FDB, 0, 0, 0));
    // R9 and R2
    send("R9", 0, 0, S_ONE, S_ONE, 1, 0, 64'h1234_5678_4049_0FDB, 3'b101, mk(64'h4049_0FDB, 0, 0, 3'b101));
    send("R9", 1, 0, D_ONE, D_ONE, 1, 0, 64'h4009_21FB_5444_2D18, 3'b011, mk(64'h4009_21FB_5444_2D18, 0, 0, 3'b011));
    send("R9", 0, 0, S_SN, S_ONE, 1, 0, 0, 3'b111, mk(64'h7FC0_0001, 1, 0, 0));
    send("R2", 0, 0, 64'hFFFF_FFFF_3F80_0000, 64'h7FF0_0000_3F80_0000, 1, 0, 64'hAAAA_AAAA_0000_0042, 3'b001, mk(64'h42, 0, 0, 3'b001));
    send("R2", 1, 0, 64'h0000_0000_7F80_0001, D_ONE, 1, 0, 64'h55, 3'b100, mk(64'h55, 0, 0, 3'b100));
    send("R2", 0, 0, 64'hDEAD_BEEF_7F80_0001, S_ONE, 1, 0, 0, 3'b000, mk(64'h7FC0_0001, 1, 0, 0));
    // R10
    send("R10", 0, 1, S_ONE, S_SN, 1, 0, 64'h3F80_0000, 3'b001, mk(64'h3F80_0000, 0, 0, 3'b001));
    send("R10", 1, 1, D_SN, D_QN, 1, 0, 0, 3'b000, mk(64'h7FF8_0000_0000_0001, 1, 0, 0));
    send("R10", 0, 1, S_ONE, S_QN, 1, 1, 0, 3'b000, mk(64'hFFC0_0000, 1, 0, 0));
    // back-to-back under stalls
    for (int k = 0; k < 12; k++)
      send("R1", 0, 0, S_ONE, S_ONE, 1, 0, 64'(k + 100), 3'b000, mk(64'(k + 100), 0, 0, 0));
    drain = 1;
    while (exp_q.size() != 0) @(posedge clk);
    repeat (3) @(posedge clk);
    #1;
    chk("R1", "idle after drain", {63'h0, out_valid}, 64'h0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule